// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block forms the result of the four partial-word operations that let software reach a word that does not sit on a word boundary. A left or right load combines bytes of an aligned memory word with the current contents of the destination register. A left or right store combines register bytes with the aligned memory word to produce the data written back. Which bytes move, and where they land, depends on the low address bits (the byte offset) and on a big-endian/little-endian mode input. The memory access that feeds the block always uses the effective address with its offset bits cleared.

A request is presented for one cycle with the operation, the offset, the endianness, the aligned memory word and the register value. One clock later the merged word appears on a registered output together with a load-valid strobe (loads) or a write-enable strobe (stores). A fault flag on the memory read cancels a load: no valid strobe is raised and the output keeps its previous value. The memory array and the register file sit outside the block.

Top module: `umerge_unit`

## Requirements
- R1: After reset, loadValid and storeWe are low and mergeOut is zero.
- R2: The op input is encoded 0 = load-left, 1 = load-right, 2 = store-left, 3 = store-right (bit 1 set means store). A request with reqValid high and no fault raises loadValid (loads) or storeWe (stores) for exactly the following cycle, with mergeOut holding the merged word in that cycle; the two strobes are never high together.
- R3: Big-endian load-left at byte offset k (0..3) returns the memory word shifted left by 8k bits, with the register's low k bytes kept; offset 0 returns the whole memory word.
- R4: Little-endian load-left at offset j behaves as big-endian load-left at offset 3-j: offset 0 places the memory low byte in bits 31:24 and keeps register bits 23:0; offset 3 returns the whole memory word.
- R5: Big-endian load-right at offset k fills the register's low k+1 bytes with the memory word shifted right by 8(3-k) bits and keeps the rest of the register; offset 3 returns the whole memory word.
- R6: Little-endian load-right at offset 0 returns the register unchanged; at offset j of 1 to 3 it fills the register's low 4-j bytes with the memory word shifted right by 8j bits and keeps the register's upper j bytes.
- R7: Big-endian store-left at offset k keeps the memory word's top k bytes and fills the rest with the register shifted right by 8k bits; offset 0 writes the whole register.
- R8: Big-endian store-right at offset k places the register shifted left by 8(3-k) bits in the word and keeps the memory word's low 3-k bytes; offset 3 writes the whole register.
- R9: Little-endian store-left and store-right at offset j produce the big-endian result of the same operation at offset 3-j.
- R10: A load request with memFault high raises no loadValid and leaves mergeOut unchanged in the following cycle.
- R11: memFault has no effect on a store: storeWe and the merged write data appear as without a fault.
- R12: A cycle with reqValid low is followed by a cycle with both strobes low and mergeOut unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| op | input | 2 | Operation: 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| offset | input | OFF_W (2) | Low bits of the effective address |
| bigEndian | input | 1 | 1 selects big-endian byte mapping, 0 little-endian |
| memWord | input | WORD_W (32) | Aligned memory word read at the cleared address |
| regVal | input | WORD_W (32) | Current register value (store source or load destination) |
| memFault | input | 1 | Memory read faulted; cancels a load |
| loadValid | output | 1 | mergeOut holds a load result |
| storeWe | output | 1 | mergeOut holds store write data |
| mergeOut | output | WORD_W (32) | Registered merged word |

## Verification
The bench builds the unit with its defaults, four lanes of eight bits, so the whole space of operation, endianness and offset is only 32 cases and each one is swept against several data pattern pairs, including all-ones against all-zeros, which exposes any byte taken from the wrong operand. Expected words come from shift-and-mask arithmetic on the 32-bit values, not from the lane selection the design uses. Fault, idle and store-with-fault cycles are placed after known results so that a held output can be told apart from a recomputed one.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'd0,
    OP_LOAD_RIGHT  = 2'd1,
    OP_STORE_LEFT  = 2'd2,
    OP_STORE_RIGHT = 2'd3
  } mergeOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;    // register a new merged word this cycle
    logic storeSide;  // kept bytes come from memory, moved bytes from register
    logic fillLow;    // moved bytes fill the low lanes (load-right / store-left)
  } ctrlStrobes_t;

endpackage

// File: rtl/umerge_control.sv
module umerge_control
  import umerge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   op,
  input  logic         memFault,
  output ctrlStrobes_t strobes,
  output logic         loadValid,
  output logic         storeWe
);

  mergeOp_e opKind;

  always_comb begin
    opKind            = mergeOp_e'(op);
    strobes.storeSide = (opKind == OP_STORE_LEFT) || (opKind == OP_STORE_RIGHT);
    strobes.fillLow   = (opKind == OP_LOAD_RIGHT) || (opKind == OP_STORE_LEFT);
    // A faulted read cancels a load; a store proceeds regardless.
    strobes.capture   = reqValid && (strobes.storeSide || !memFault);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      storeWe   <= 1'b0;
    end else begin
      loadValid <= reqValid && !strobes.storeSide && !memFault;
      storeWe   <= reqValid && strobes.storeSide;
    end
  end

endmodule

// File: rtl/umerge_datapath.sv
module umerge_datapath
  import umerge_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W,
  localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [OFF_W-1:0]  offset,
  input  logic              bigEndian,
  input  logic [WORD_W-1:0] memWord,
  input  logic [WORD_W-1:0] regVal,
  output logic [WORD_W-1:0] mergeOut
);

  logic [LANES-1:0][LANE_W-1:0] keptLanes;
  logic [LANES-1:0][LANE_W-1:0] movedLanes;
  logic [LANES-1:0][LANE_W-1:0] laneRes;
  int kIdx;     // offset expressed in big-endian order
  int keepLow;  // low lanes kept when moved bytes fill upward
  int fillCnt;  // low lanes filled when moved bytes fill downward

  always_comb begin
    keptLanes  = strobes.storeSide ? memWord : regVal;
    movedLanes = strobes.storeSide ? regVal  : memWord;
    kIdx       = bigEndian ? int'(offset) : (LANES - 1) - int'(offset);
    keepLow    = strobes.storeSide ? (LANES - 1) - kIdx : kIdx;
    if (strobes.storeSide)
      fillCnt = LANES - kIdx;
    else if (!bigEndian && (offset == '0))
      fillCnt = 0;  // little-endian load-right at offset 0 leaves the register
    else
      fillCnt = kIdx + 1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OFF_W-1:0]  srcUp;
    logic [OFF_W-1:0]  srcDown;
    logic [LANE_W-1:0] laneVal;

    always_comb begin
      srcUp   = OFF_W'(g - keepLow);
      srcDown = OFF_W'(g + LANES - fillCnt);
      laneVal = keptLanes[g];
      if (strobes.fillLow) begin
        if (g < fillCnt) laneVal = movedLanes[srcDown];
      end else begin
        if (g >= keepLow) laneVal = movedLanes[srcUp];
      end
    end

    assign laneRes[g] = laneVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      mergeOut <= '0;
    else if (strobes.capture)
      mergeOut <= laneRes;
  end

endmodule

// File: rtl/umerge_unit.sv
module umerge_unit
  import umerge_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W,
  localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        op,
  input  logic [OFF_W-1:0]  offset,
  input  logic              bigEndian,
  input  logic [WORD_W-1:0] memWord,
  input  logic [WORD_W-1:0] regVal,
  input  logic              memFault,
  output logic              loadValid,
  output logic              storeWe,
  output logic [WORD_W-1:0] mergeOut
);

  ctrlStrobes_t strobes;

  umerge_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .op        (op),
    .memFault  (memFault),
    .strobes   (strobes),
    .loadValid (loadValid),
    .storeWe   (storeWe)
  );

  umerge_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .offset    (offset),
    .bigEndian (bigEndian),
    .memWord   (memWord),
    .regVal    (regVal),
    .mergeOut  (mergeOut)
  );

endmodule

// File: rtl/umerge_checker.sv
module umerge_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W,
  localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        op,
  input logic [OFF_W-1:0]  offset,
  input logic              bigEndian,
  input logic [WORD_W-1:0] memWord,
  input logic [WORD_W-1:0] regVal,
  input logic              memFault,
  input logic              loadValid,
  input logic              storeWe,
  input logic [WORD_W-1:0] mergeOut
);

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(loadValid && storeWe));

  assert_load_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !op[1] && !memFault) |=> loadValid);

  assert_store_ignores_fault_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && op[1]) |=> (storeWe && !loadValid));

  assert_fault_cancels_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !op[1] && memFault) |=> (!loadValid && $stable(mergeOut)));

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!loadValid && !storeWe && $stable(mergeOut)));

  assert_le_right_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && op == 2'd1 && !bigEndian && offset == '0 && !memFault)
      |=> (mergeOut == $past(regVal)));

  assert_be_left_whole_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && op == 2'd0 && bigEndian && offset == '0 && !memFault)
      |=> (mergeOut == $past(memWord)));

  assert_be_store_right_whole_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && op == 2'd3 && bigEndian && offset == OFF_W'(LANES - 1))
      |=> (mergeOut == $past(regVal)));

endmodule

bind umerge_unit umerge_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .op        (op),
  .offset    (offset),
  .bigEndian (bigEndian),
  .memWord   (memWord),
  .regVal    (regVal),
  .memFault  (memFault),
  .loadValid (loadValid),
  .storeWe   (storeWe),
  .mergeOut  (mergeOut)
);

// File: tb/umerge_unit_tb.sv
`timescale 1ns/1ps
module umerge_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [1:0]  offset = 2'd0;
  logic        bigEndian = 1'b0;
  logic [31:0] memWord = '0;
  logic [31:0] regVal = '0;
  logic        memFault = 1'b0;
  logic        loadValid;
  logic        storeWe;
  logic [31:0] mergeOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  umerge_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .op(op), .offset(offset),
    .bigEndian(bigEndian), .memWord(memWord), .regVal(regVal),
    .memFault(memFault), .loadValid(loadValid), .storeWe(storeWe),
    .mergeOut(mergeOut)
  );

  function automatic logic [63:0] lowMask(int bits);
    return (64'd1 << bits) - 64'd1;
  endfunction

  // Expected merged word from shift-and-mask arithmetic.
  function automatic logic [31:0] expectWord(int opc, int off, bit be,
                                             logic [31:0] w, logic [31:0] r);
    logic [63:0] w64 = {32'd0, w};
    logic [63:0] r64 = {32'd0, r};
    logic [63:0] res;
    int k = be ? off : 3 - off;
    case (opc)
      0: res = (w64 << (8 * k)) | (r64 & lowMask(8 * k));
      1: begin
        if (be)
          res = (r64 & ~lowMask(8 * (k + 1))) | (w64 >> (8 * (3 - k)));
        else if (off == 0)
          res = r64;
        else
          res = (r64 & ~lowMask(8 * (4 - off))) | (w64 >> (8 * off));
      end
      2: res = (w64 & ~lowMask(32 - 8 * k)) | (r64 >> (8 * k));
      default: res = (r64 << (8 * (3 - k))) | (w64 & lowMask(8 * (3 - k)));
    endcase
    return res[31:0];
  endfunction

  function automatic string reqTag(int opc, bit be);
    case (opc)
      0: return be ? "R3" : "R4";
      1: return be ? "R5" : "R6";
      2: return be ? "R7" : "R9";
      default: return be ? "R8" : "R9";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge, sample just after the next rising edge.
  task automatic issue(int opc, int off, bit be, logic [31:0] w, logic [31:0] r,
                       bit fault);
    @(negedge clk);
    reqValid  = 1'b1;
    op        = 2'(opc);
    offset    = 2'(off);
    bigEndian = be;
    memWord   = w;
    regVal    = r;
    memFault  = fault;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    logic [31:0] patW [4];
    logic [31:0] patR [4];
    logic [31:0] held;
    patW[0] = 32'h11223344; patR[0] = 32'hAABBCCDD;
    patW[1] = 32'hFFFFFFFF; patR[1] = 32'h00000000;
    patW[2] = 32'h00000000; patR[2] = 32'hFFFFFFFF;
    patW[3] = 32'h8F1E2D3C; patR[3] = 32'h5A6B7C0D;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "loadValid", 32'(loadValid), 32'd0);
    check("R1", "storeWe", 32'(storeWe), 32'd0);
    check("R1", "mergeOut", mergeOut, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3..R9 and R2: full sweep of operation, endianness and offset
    for (int p = 0; p < 4; p++) begin
      for (int be = 0; be < 2; be++) begin
        for (int opc = 0; opc < 4; opc++) begin
          for (int off = 0; off < 4; off++) begin
            issue(opc, off, be[0], patW[p], patR[p], 1'b0);
            check(reqTag(opc, be[0]), $sformatf("op%0d be%0d off%0d", opc, be, off),
                  mergeOut, expectWord(opc, off, be[0], patW[p], patR[p]));
            check("R2", "strobes", {30'd0, loadValid, storeWe},
                  (opc < 2) ? 32'd2 : 32'd1);
          end
        end
      end
    end

    // R10: faulted load leaves output and strobe low
    issue(0, 0, 1'b1, 32'hCAFEF00D, 32'h0, 1'b0);
    held = mergeOut;
    check("R3", "known word before fault", held, 32'hCAFEF00D);
    issue(1, 2, 1'b1, 32'h12345678, 32'h9ABCDEF0, 1'b1);
    check("R10", "loadValid on fault", 32'(loadValid), 32'd0);
    check("R10", "mergeOut held on fault", mergeOut, held);

    // R11: faulted store still writes
    issue(2, 1, 1'b1, 32'h01020304, 32'hA1B2C3D4, 1'b1);
    check("R11", "storeWe with fault", 32'(storeWe), 32'd1);
    check("R11", "store data with fault", mergeOut,
          expectWord(2, 1, 1'b1, 32'h01020304, 32'hA1B2C3D4));
    held = mergeOut;

    // R12: idle cycle holds output
    @(negedge clk);
    reqValid = 1'b0;
    op       = 2'd0;
    memWord  = 32'hDEADBEEF;
    regVal   = 32'h0BADF00D;
    @(posedge clk);
    #1;
    check("R12", "strobes idle", {30'd0, loadValid, storeWe}, 32'd0);
    check("R12", "mergeOut idle", mergeOut, held);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule